// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is a down-counting interval timer that software programs through a small register port. Writing a start value to the count register stores it as the reload value and starts a countdown from it. The count steps down by one on every cycle in which the timer-clock enable `tickEn` is high. When the count runs out, a sticky expiry flag is set and, if enabled, an interrupt line goes high. Software clears the flag by writing a one to it.

The timer runs only when two conditions hold: the interrupt-enable control bit is set, and the stored reload value is at least 2. If either condition fails, the count holds its value. After an expiry the timer does one of two things:

- With the auto-reload control bit set, it restarts from the stored reload value, so it fires once every "reload value" ticks.
- With auto-reload clear, it parks at zero until software writes the count register again.

Top module: `pit_timer`

## Requirements
- R1: After reset the count, the reload value, both control bits and the expiry flag read as 0, and `irq` is low.
- R2: A write to address 0 stores `wrData[CW-1:0]` as the reload value and loads the count with it on the same clock edge. A write while the timer is counting restarts the countdown from the new value.
- R3: While running, the count drops by exactly one on each clock edge where `tickEn` is high. On edges where `tickEn` is low, it holds.
- R4: The timer runs only while control bit 0 (interrupt enable, address 1) is set. While that bit is clear, the count holds. Setting the bit again resumes counting from the held value.
- R5: A reload value of 0 or 1 keeps the timer stopped: the count holds and no expiry occurs.
- R6: A tick that arrives while the count is 1 or less is an expiry, and it sets the expiry flag (status bit 0, address 2). With reload value N ≥ 2, the first expiry falls on the N-th tick after the write.
- R7: With control bit 1 (auto-reload) set, an expiry reloads the count with the stored reload value and counting continues. With the bit clear, the count becomes 0 and the timer stays stopped, setting no further flags, until address 0 is written again.
- R8: `irq` is high exactly when the expiry flag is set and control bit 0 is set.
- R9: Writing address 2 with bit 0 at 1 clears the expiry flag, and writing bit 0 at 0 leaves it unchanged. An expiry on the same edge as a clear leaves the flag set.
- R10: `rdData` returns the current count (zero-extended) for address 0, the two control bits at bits 1:0 for address 1, the expiry flag at bit 0 for address 2, and zero for address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer-clock enable; one count step per high cycle |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wrData | input | DW | Write data |
| rdData | output | DW | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted run/stop decision appears on the very next tick as a count at address 0 that moved when it should have held, or held when it should have moved. A wrong reload or park choice after expiry shows up on the first read after the expiring tick. Errors in the expiry flag or its clear show on `irq` one edge after the event. Because every state element is readable or drives `irq`, no fault stays hidden for more than one period of the programmed interval.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // Strobes the control unit hands to the count datapath (at most one per cycle).
  typedef struct packed {
    logic loadNew;      // store write data as reload value and count
    logic reloadCount;  // expiry with auto-reload: count <= reload value
    logic decrement;    // ordinary tick: count <= count - 1
    logic clearCount;   // expiry without auto-reload: count <= 0
  } pitStrobe_t;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam int CTRL_IRQ_EN_BIT = 0;
  localparam int CTRL_AUTO_BIT   = 1;
  localparam int STATUS_EXP_BIT  = 0;

endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  pitStrobe_t    strobe,
  input  logic [DW-1:0] wrData,
  output logic [CW-1:0] countVal,
  output logic [CW-1:0] reloadVal,
  output logic          reloadUsable,
  output logic          countAtEnd
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] countQ;
  logic [CW-1:0] reloadQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      reloadQ <= '0;
    end else if (strobe.loadNew) begin
      reloadQ <= wrData[CW-1:0];
      countQ  <= wrData[CW-1:0];
    end else if (strobe.reloadCount) begin
      countQ  <= reloadQ;
    end else if (strobe.decrement) begin
      countQ  <= countQ - ONE;
    end else if (strobe.clearCount) begin
      countQ  <= '0;
    end
  end

  assign countVal     = countQ;
  assign reloadVal    = reloadQ;
  assign reloadUsable = (reloadQ > ONE);
  assign countAtEnd   = (countQ <= ONE);

  // R3: a decrement strobe takes exactly one off the count
  p_dec_by_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decrement |=> countQ == $past(countQ) - ONE);

  // R2: a load strobe places the written value in both registers
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadNew |=> (countQ == $past(wrData[CW-1:0])) && (reloadQ == countQ));

  // R7: a reload strobe restores the stored reload value
  p_reload_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reloadCount |=> countQ == reloadQ);

endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          wrEn,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wrData,
  input  logic [CW-1:0] countVal,
  input  logic          reloadUsable,
  input  logic          countAtEnd,
  output pitStrobe_t    strobe,
  output logic          irqEn,
  output logic          autoReload,
  output logic          statusFlag,
  output logic          irq
);

  logic armed;
  logic running;
  logic expire;
  logic wrCount;
  logic wrCtrl;
  logic wrStatus;

  assign wrCount  = wrEn && (addr == ADDR_COUNT);
  assign wrCtrl   = wrEn && (addr == ADDR_CTRL);
  assign wrStatus = wrEn && (addr == ADDR_STATUS);

  assign running = armed && irqEn && reloadUsable;
  assign expire  = running && tickEn && countAtEnd && !wrCount;

  always_comb begin
    strobe             = '0;
    strobe.loadNew     = wrCount;
    strobe.decrement   = running && tickEn && !countAtEnd && !wrCount;
    strobe.reloadCount = expire && autoReload;
    strobe.clearCount  = expire && !autoReload;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn      <= 1'b0;
      autoReload <= 1'b0;
    end else if (wrCtrl) begin
      irqEn      <= wrData[CTRL_IRQ_EN_BIT];
      autoReload <= wrData[CTRL_AUTO_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (wrCount) begin
      armed <= 1'b1;
    end else if (expire && !autoReload) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusFlag <= 1'b0;
    end else if (expire) begin
      statusFlag <= 1'b1;
    end else if (wrStatus && wrData[STATUS_EXP_BIT]) begin
      statusFlag <= 1'b0;
    end
  end

  assign irq = statusFlag && irqEn;

  // at most one datapath action per cycle
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadNew, strobe.reloadCount, strobe.decrement, strobe.clearCount}));

  // R6: an expiry always leaves the flag set
  p_expire_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> statusFlag);

  // R4: with interrupt enable clear and no write, the count holds
  p_hold_disabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn && !wrCount) |=> $stable(countVal));

  // R5: an unusable reload value never lets the count move
  p_short_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!reloadUsable && !wrCount) |=> $stable(countVal));

  // R9: a clear without a coinciding expiry drops the flag
  p_clear_w1c_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && wrData[STATUS_EXP_BIT] && !expire) |=> !statusFlag);

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          wrEn,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          irq
);

  pitStrobe_t    strobe;
  logic [CW-1:0] countVal;
  logic [CW-1:0] reloadVal;
  logic          reloadUsable;
  logic          countAtEnd;
  logic          irqEn;
  logic          autoReload;
  logic          statusFlag;
  logic [DW-1:0] countExt;

  pit_ctrl #(.DW(DW), .CW(CW)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tickEn       (tickEn),
    .wrEn         (wrEn),
    .addr         (addr),
    .wrData       (wrData),
    .countVal     (countVal),
    .reloadUsable (reloadUsable),
    .countAtEnd   (countAtEnd),
    .strobe       (strobe),
    .irqEn        (irqEn),
    .autoReload   (autoReload),
    .statusFlag   (statusFlag),
    .irq          (irq)
  );

  pit_datapath #(.DW(DW), .CW(CW)) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .countVal     (countVal),
    .reloadVal    (reloadVal),
    .reloadUsable (reloadUsable),
    .countAtEnd   (countAtEnd)
  );

  generate
    if (DW > CW) begin : g_pad
      assign countExt = {{(DW-CW){1'b0}}, countVal};
    end else begin : g_nopad
      assign countExt = countVal;
    end
  endgenerate

  // R10: read mux
  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_COUNT:  rdData = countExt;
      ADDR_CTRL: begin
        rdData[CTRL_IRQ_EN_BIT] = irqEn;
        rdData[CTRL_AUTO_BIT]   = autoReload;
      end
      ADDR_STATUS: rdData[STATUS_EXP_BIT] = statusFlag;
      default:     rdData = '0;
    endcase
  end

  // R8: an interrupt never appears without a set flag
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rdData != '0 || addr != ADDR_STATUS));

  // R2: the stored reload value always tracks the last count write
  p_reload_tracks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_COUNT) |=> reloadVal == $past(wrData[CW-1:0]));

endmodule

// File: tb/test_pit_timer.sv
module test_pit_timer;

  localparam int DW = 32;
  localparam int CW = 16;
  localparam int NVEC = 9;

  // {reload, auto, ticks, expCount, expFlag}
  typedef struct packed {
    logic [15:0] reload;
    logic        autoR;
    logic [15:0] ticks;
    logic [15:0] expCount;
    logic        expFlag;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'd5, 1'b0, 16'd3,  16'd2, 1'b0},
    '{16'd5, 1'b0, 16'd5,  16'd0, 1'b1},
    '{16'd5, 1'b0, 16'd9,  16'd0, 1'b1},
    '{16'd4, 1'b1, 16'd4,  16'd4, 1'b1},
    '{16'd4, 1'b1, 16'd6,  16'd2, 1'b1},
    '{16'd1, 1'b1, 16'd10, 16'd1, 1'b0},
    '{16'd0, 1'b0, 16'd10, 16'd0, 1'b0},
    '{16'd2, 1'b1, 16'd7,  16'd1, 1'b1},
    '{16'd3, 1'b0, 16'd2,  16'd1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pit_timer #(.DW(DW), .CW(CW)) i_pit_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic runTicks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(2'd0, v); check("R1 count", v, 0);
    readReg(2'd1, v); check("R1 ctrl", v, 0);
    readReg(2'd2, v); check("R1 flag", v, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // vector table: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      wrReg(2'd1, {30'd0, VECS[i].autoR, 1'b1});
      wrReg(2'd2, 32'd1);
      wrReg(2'd0, {16'd0, VECS[i].reload});
      runTicks(int'(VECS[i].ticks));
      readReg(2'd0, v); check("R6/R7 vector count", v, {16'd0, VECS[i].expCount});
      readReg(2'd2, v); check("R6/R5 vector flag", v, {31'd0, VECS[i].expFlag});
      check("R8 vector irq", {31'd0, irq}, {31'd0, VECS[i].expFlag});
    end

    // R4: disabled timer holds, then resumes
    wrReg(2'd1, 32'd0);
    wrReg(2'd2, 32'd1);
    wrReg(2'd0, 32'd6);
    runTicks(4);
    readReg(2'd0, v); check("R4 hold while disabled", v, 6);
    wrReg(2'd1, 32'd1);
    runTicks(2);
    readReg(2'd0, v); check("R4 resume", v, 4);

    // R3: tickEn low holds the count
    repeat (5) @(negedge clk);
    readReg(2'd0, v); check("R3 no tick hold", v, 4);

    // R2: rewrite mid-count restarts
    wrReg(2'd0, 32'd8);
    runTicks(3);
    readReg(2'd0, v); check("R2 count before rewrite", v, 5);
    wrReg(2'd0, 32'd10);
    readReg(2'd0, v); check("R2 restart", v, 10);
    runTicks(1);
    readReg(2'd0, v); check("R3 single tick", v, 9);

    // R9: clear behaviour, R8 masking
    wrReg(2'd0, 32'd2);
    runTicks(2);
    readReg(2'd2, v); check("R6 flag at N ticks", v, 1);
    wrReg(2'd2, 32'd0);
    readReg(2'd2, v); check("R9 write zero no effect", v, 1);
    wrReg(2'd1, 32'd0);
    check("R8 irq masked", {31'd0, irq}, 0);
    readReg(2'd2, v); check("R8 flag kept when masked", v, 1);
    wrReg(2'd1, 32'd1);
    check("R8 irq unmasked", {31'd0, irq}, 1);
    wrReg(2'd2, 32'd1);
    readReg(2'd2, v); check("R9 clear", v, 0);
    check("R9 irq after clear", {31'd0, irq}, 0);

    // R9: expiry wins over simultaneous clear
    wrReg(2'd0, 32'd3);
    runTicks(2);
    @(negedge clk);
    tickEn = 1'b1; wrEn = 1'b1; addr = 2'd2; wrData = 32'd1;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0; wrData = '0;
    readReg(2'd2, v); check("R9 expiry beats clear", v, 1);

    // R7: stopped after non-auto expiry, sets nothing more
    wrReg(2'd2, 32'd1);
    runTicks(6);
    readReg(2'd2, v); check("R7 no flag while parked", v, 0);
    readReg(2'd0, v); check("R7 parked count", v, 0);

    // R10 readbacks
    wrReg(2'd1, 32'h3);
    readReg(2'd1, v); check("R10 ctrl readback", v, 3);
    readReg(2'd3, v); check("R10 unused address", v, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule